// File: doc/BRIEF.md
# Indirect Configuration and IO Access Port

This block lets a processor reach a downstream configuration space and IO space through a small register window. Software first writes a 32-bit pointer register that selects a downstream location. It then reads or writes one of two data windows. Each data-window access becomes a single downstream request, whose address is the pointer with its two low bits cleared, combined with the byte offset of the upstream access.

The configuration window moves bytes in little-endian lane order. The IO window reverses the byte order of 2- and 4-byte accesses. The upstream port carries 1-, 2- or 4-byte accesses and checks each one for legality. A combination of size and offset that is not allowed is answered with an error and never reaches the downstream side.

Only one downstream request is outstanding at any time. The upstream side stalls until the response comes back. A fourth register holds a timeout-command word, built from a fixed base value and a few bits that software may set.

Top module: `iap_port`

## Requirements
- R1: After reset the pointer register reads 0. A 4-byte write to it stores all 32 bits, and a later read returns that value unchanged, including bits 1:0.
- R2: The pointer register (word 0, up_addr[3:2]=0) and the timeout-command register (word 3) accept only size code 2 (4 bytes) at byte offset 0. Any other access to them is illegal.
- R3: The downstream address is the pointer with bits 1:0 forced to zero, ORed with up_addr[1:0]. No enable bit and no high address bit gates the access.
- R4: In the data windows (word 1 = configuration, word 2 = IO), legality depends on the byte offset:
  - byte offset 0 accepts size codes 0, 1 and 2 (1, 2 and 4 bytes);
  - byte offset 2 accepts codes 0 and 1;
  - byte offsets 1 and 3 accept only code 0;
  - size code 3 is always illegal.
- R5: An illegal access completes one cycle after it is accepted, with up_err=1 and up_rdata=0. It issues no downstream request and changes no register.
- R6: Data lanes are right-justified on both sides, and unused upper lanes read as zero.
  - The configuration window (dn_space=0) passes bytes unchanged.
  - The IO window (dn_space=1) swaps the two bytes of a 2-byte access and reverses all four bytes of a 4-byte access, for both write data and read data.
- R7: The timeout-command register resets to TOC_BASE (default 0xFFFA0030). A legal write stores TOC_BASE | (wdata & TOC_KEEP), with TOC_KEEP defaulting to 0x0001E000.
- R8: A legal data-window access raises dn_valid in the cycle after acceptance.
  - dn_valid and the request fields hold steady until dn_rsp is sampled high.
  - up_ready stays low while dn_valid is high.
  - up_done pulses in the cycle after dn_rsp, carrying the converted read data (0 for writes).
- R9: In reset, up_ready=1, dn_valid=0 and up_done=0. Register accesses complete one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Upstream access request, accepted when up_ready is high |
| up_ready | output | 1 | Port idle and able to accept an access |
| up_we | input | 1 | 1 = write, 0 = read |
| up_addr | input | 4 | [3:2] register word, [1:0] byte offset |
| up_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| up_wdata | input | 32 | Right-justified write data |
| up_done | output | 1 | One-cycle completion pulse |
| up_err | output | 1 | Completion carries an error |
| up_rdata | output | 32 | Right-justified read data |
| dn_valid | output | 1 | Downstream request pending |
| dn_space | output | 1 | 0 = configuration, 1 = IO |
| dn_we | output | 1 | Downstream write |
| dn_addr | output | 32 | Downstream byte address |
| dn_size | output | 2 | Downstream size code |
| dn_wdata | output | 32 | Downstream write data in little-endian lanes |
| dn_rsp | input | 1 | Downstream response, completes the pending request |
| dn_rdata | input | 32 | Downstream read data in little-endian lanes |

## Verification
The bench builds the port with its default TOC_BASE and TOC_KEEP. This makes the timeout-command masking visible: writing all ones must read back as 0xFFFBE030.

A responder in the bench holds each downstream request for several cycles before answering. This exposes the stall and the field stability while a request is pending.

The pointer values are chosen to cover three cases:
- a value whose low bits are set, which shows the difference between the readback and the downstream address;
- a value whose top bit is clear, which shows that nothing gates the access;
- an all-ones value, which shows the OR with the byte offset.

// File: rtl/iap_pkg.sv
package iap_pkg;
    localparam int DW = 32;
    localparam int NB = DW / 8;

    typedef enum logic [1:0] {
        SZ_B   = 2'd0,
        SZ_H   = 2'd1,
        SZ_W   = 2'd2,
        SZ_BAD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        RG_PTR = 2'd0,
        RG_CFG = 2'd1,
        RG_IO  = 2'd2,
        RG_TOC = 2'd3
    } region_e;

    typedef struct packed {
        logic      legal;
        logic      is_win;
        region_e   region;
        logic [1:0] boff;
    } decode_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } state_e;

    // Alignment rule shared by both data windows.
    function automatic logic win_size_ok(size_e sz, logic [1:0] off);
        case (sz)
            SZ_B:    return 1'b1;
            SZ_H:    return (off[0] == 1'b0);
            SZ_W:    return (off == 2'b00);
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/iap_decode.sv
module iap_decode
    import iap_pkg::*;
(
    input  logic [3:0] addr,
    input  size_e      size,
    output decode_t    dec
);
    always_comb begin
        dec.region = region_e'(addr[3:2]);
        dec.boff   = addr[1:0];
        dec.is_win = (dec.region == RG_CFG) || (dec.region == RG_IO);
        if (dec.is_win) begin
            dec.legal = win_size_ok(size, addr[1:0]);
        end else begin
            dec.legal = (size == SZ_W) && (addr[1:0] == 2'b00);
        end
    end
endmodule

// File: rtl/iap_lanes.sv
module iap_lanes
    import iap_pkg::*;
(
    input  logic [DW-1:0] din,
    input  size_e         size,
    input  logic          swap,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] rev_all;

    genvar i;
    generate
        for (i = 0; i < NB; i++) begin : g_rev
            assign rev_all[8*i +: 8] = din[8*(NB-1-i) +: 8];
        end
    endgenerate

    always_comb begin
        case (size)
            SZ_W: begin
                dout = swap ? rev_all : din;
            end
            SZ_H: begin
                if (swap) begin
                    dout = {{(DW-16){1'b0}}, din[7:0], din[15:8]};
                end else begin
                    dout = {{(DW-16){1'b0}}, din[15:0]};
                end
            end
            default: begin
                dout = {{(DW-8){1'b0}}, din[7:0]};
            end
        endcase
    end
endmodule

// File: rtl/iap_ctrl.sv
module iap_ctrl
    import iap_pkg::*;
#(
    parameter logic [DW-1:0] TOC_BASE = 32'hFFFA_0030,
    parameter logic [DW-1:0] TOC_KEEP = 32'h0001_E000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          up_req,
    input  logic          up_we,
    input  size_e         up_size,
    input  logic [DW-1:0] up_wdata,
    input  decode_t       dec,
    input  logic [DW-1:0] wr_lane,
    input  logic [DW-1:0] rd_lane,
    input  logic          dn_rsp,
    output logic          up_ready,
    output logic          up_done,
    output logic          up_err,
    output logic [DW-1:0] up_rdata,
    output logic          dn_valid,
    output logic          dn_space,
    output logic          dn_we,
    output logic [DW-1:0] dn_addr,
    output size_e         dn_size,
    output logic [DW-1:0] dn_wdata
);
    state_e        state_q;
    logic [DW-1:0] ptr_q;
    logic [DW-1:0] toc_q;

    assign up_ready = (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            ptr_q    <= '0;
            toc_q    <= TOC_BASE;
            up_done  <= 1'b0;
            up_err   <= 1'b0;
            up_rdata <= '0;
            dn_valid <= 1'b0;
            dn_space <= 1'b0;
            dn_we    <= 1'b0;
            dn_addr  <= '0;
            dn_size  <= SZ_B;
            dn_wdata <= '0;
        end else begin
            up_done <= 1'b0;
            up_err  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (up_req) begin
                        if (!dec.legal) begin
                            up_done  <= 1'b1;
                            up_err   <= 1'b1;
                            up_rdata <= '0;
                        end else if (dec.is_win) begin
                            dn_valid <= 1'b1;
                            dn_we    <= up_we;
                            dn_space <= (dec.region == RG_IO);
                            dn_addr  <= {ptr_q[DW-1:2], 2'b00} | {{(DW-2){1'b0}}, dec.boff};
                            dn_size  <= up_size;
                            dn_wdata <= up_we ? wr_lane : '0;
                            state_q  <= ST_WAIT;
                        end else begin
                            up_done  <= 1'b1;
                            up_rdata <= '0;
                            if (dec.region == RG_PTR) begin
                                if (up_we) ptr_q <= up_wdata;
                                else       up_rdata <= ptr_q;
                            end else begin
                                if (up_we) toc_q <= TOC_BASE | (up_wdata & TOC_KEEP);
                                else       up_rdata <= toc_q;
                            end
                        end
                    end
                end
                ST_WAIT: begin
                    if (dn_rsp) begin
                        dn_valid <= 1'b0;
                        up_done  <= 1'b1;
                        up_rdata <= dn_we ? '0 : rd_lane;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/iap_port.sv
module iap_port
    import iap_pkg::*;
#(
    parameter logic [31:0] TOC_BASE = 32'hFFFA_0030,
    parameter logic [31:0] TOC_KEEP = 32'h0001_E000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        up_req,
    output logic        up_ready,
    input  logic        up_we,
    input  logic [3:0]  up_addr,
    input  logic [1:0]  up_size,
    input  logic [31:0] up_wdata,
    output logic        up_done,
    output logic        up_err,
    output logic [31:0] up_rdata,
    output logic        dn_valid,
    output logic        dn_space,
    output logic        dn_we,
    output logic [31:0] dn_addr,
    output logic [1:0]  dn_size,
    output logic [31:0] dn_wdata,
    input  logic        dn_rsp,
    input  logic [31:0] dn_rdata
);
    decode_t       dec;
    size_e         dn_size_e;
    logic [DW-1:0] wr_lane;
    logic [DW-1:0] rd_lane;

    iap_decode u_dec (
        .addr (up_addr),
        .size (size_e'(up_size)),
        .dec  (dec)
    );

    iap_lanes u_wr_lanes (
        .din  (up_wdata),
        .size (size_e'(up_size)),
        .swap (dec.region == RG_IO),
        .dout (wr_lane)
    );

    iap_lanes u_rd_lanes (
        .din  (dn_rdata),
        .size (dn_size_e),
        .swap (dn_space),
        .dout (rd_lane)
    );

    iap_ctrl #(
        .TOC_BASE (TOC_BASE),
        .TOC_KEEP (TOC_KEEP)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .up_req   (up_req),
        .up_we    (up_we),
        .up_size  (size_e'(up_size)),
        .up_wdata (up_wdata),
        .dec      (dec),
        .wr_lane  (wr_lane),
        .rd_lane  (rd_lane),
        .dn_rsp   (dn_rsp),
        .up_ready (up_ready),
        .up_done  (up_done),
        .up_err   (up_err),
        .up_rdata (up_rdata),
        .dn_valid (dn_valid),
        .dn_space (dn_space),
        .dn_we    (dn_we),
        .dn_addr  (dn_addr),
        .dn_size  (dn_size_e),
        .dn_wdata (dn_wdata)
    );

    assign dn_size = dn_size_e;
endmodule

// File: rtl/iap_port_chk.sv
module iap_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        up_ready,
    input logic        up_done,
    input logic        up_err,
    input logic        dn_valid,
    input logic        dn_we,
    input logic [31:0] dn_addr,
    input logic [1:0]  dn_size,
    input logic        dn_rsp
);
    // R8: request fields hold until the response arrives
    p_hold_fields_r8: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !dn_rsp) |=> (dn_valid && $stable(dn_addr) && $stable(dn_size) && $stable(dn_we)));

    // R8: upstream stalls while a request is pending
    p_stall_r8: assert property (@(posedge clk) disable iff (rst)
        dn_valid |-> !up_ready);

    // R8: completion follows the response by one cycle
    p_done_after_rsp_r8: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && dn_rsp) |=> (up_done && !dn_valid));

    // R5: an error completion never coexists with a downstream request
    p_err_no_req_r5: assert property (@(posedge clk) disable iff (rst)
        (up_done && up_err) |-> (!dn_valid && up_ready));

    // R4: no reserved size reaches the downstream side
    p_size_legal_r4: assert property (@(posedge clk) disable iff (rst)
        dn_valid |-> (dn_size != 2'd3));

    // R4: a 4-byte request is word aligned
    p_aligned_r4: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && dn_size == 2'd2) |-> (dn_addr[1:0] == 2'b00));
endmodule

bind iap_port iap_port_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .up_ready (up_ready),
    .up_done  (up_done),
    .up_err   (up_err),
    .dn_valid (dn_valid),
    .dn_we    (dn_we),
    .dn_addr  (dn_addr),
    .dn_size  (dn_size),
    .dn_rsp   (dn_rsp)
);

// File: tb/tb_iap_port.sv
`timescale 1ns/1ps
module tb_iap_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        up_req = 1'b0;
    logic        up_ready;
    logic        up_we = 1'b0;
    logic [3:0]  up_addr = '0;
    logic [1:0]  up_size = '0;
    logic [31:0] up_wdata = '0;
    logic        up_done;
    logic        up_err;
    logic [31:0] up_rdata;
    logic        dn_valid;
    logic        dn_space;
    logic        dn_we;
    logic [31:0] dn_addr;
    logic [1:0]  dn_size;
    logic [31:0] dn_wdata;
    logic        dn_rsp = 1'b0;
    logic [31:0] dn_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    logic [31:0] q_data[$];
    logic        q_err[$];
    string       q_tag[$];

    always #10 clk = ~clk;

    iap_port dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each completion
    always @(negedge clk) begin
        if (!rst && up_done) begin
            if (q_data.size() == 0) begin
                check("R9 unexpected completion", 32'd1, 32'd0);
            end else begin
                automatic logic [31:0] ed = q_data.pop_front();
                automatic logic        ee = q_err.pop_front();
                automatic string       tg = q_tag.pop_front();
                check({tg, " rdata"}, up_rdata, ed);
                check({tg, " err"}, {31'd0, up_err}, {31'd0, ee});
            end
        end
    end

    // Register access or illegal access: completes with no downstream request
    task automatic reg_acc(input logic we, input logic [3:0] a, input logic [1:0] sz,
                           input logic [31:0] wd, input logic [31:0] exp_rd,
                           input logic exp_err, input string tag);
        q_data.push_back(exp_rd);
        q_err.push_back(exp_err);
        q_tag.push_back(tag);
        @(negedge clk);
        up_req = 1'b1; up_we = we; up_addr = a; up_size = sz; up_wdata = wd;
        @(negedge clk);
        up_req = 1'b0;
        check({tag, " no downstream request"}, {31'd0, dn_valid}, 32'd0);
    endtask

    // Data-window access answered by the responder after a delay
    task automatic win_acc(input logic we, input logic [3:0] a, input logic [1:0] sz,
                           input logic [31:0] wd, input logic [31:0] e_addr,
                           input logic [31:0] e_wdata, input logic [31:0] rsp,
                           input logic [31:0] exp_rd, input string tag);
        q_data.push_back(exp_rd);
        q_err.push_back(1'b0);
        q_tag.push_back(tag);
        @(negedge clk);
        up_req = 1'b1; up_we = we; up_addr = a; up_size = sz; up_wdata = wd;
        @(negedge clk);
        up_req = 1'b0;
        check({tag, " dn_valid"}, {31'd0, dn_valid}, 32'd1);
        check({tag, " dn_addr"}, dn_addr, e_addr);
        check({tag, " dn_wdata"}, dn_wdata, e_wdata);
        check({tag, " dn_space"}, {31'd0, dn_space}, {31'd0, a[3:2] == 2'd2});
        check({tag, " dn_size"}, {30'd0, dn_size}, {30'd0, sz});
        check({tag, " dn_we"}, {31'd0, dn_we}, {31'd0, we});
        repeat (2) @(negedge clk);
        check("R8 request held", {31'd0, dn_valid}, 32'd1);
        check("R8 upstream stalled", {31'd0, up_ready}, 32'd0);
        dn_rsp = 1'b1; dn_rdata = rsp;
        @(negedge clk);
        dn_rsp = 1'b0; dn_rdata = 32'hDEAD_BEEF;
        check("R8 request retired", {31'd0, dn_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset up_ready", {31'd0, up_ready}, 32'd1);
        check("R9 reset dn_valid", {31'd0, dn_valid}, 32'd0);
        check("R9 reset up_done", {31'd0, up_done}, 32'd0);
        rst = 1'b0;

        reg_acc(0, 4'h0, 2'd2, 0, 32'h0, 0, "R1 pointer reset");
        reg_acc(0, 4'hC, 2'd2, 0, 32'hFFFA_0030, 0, "R7 toc reset");
        reg_acc(1, 4'h0, 2'd2, 32'h8000_0007, 32'h0, 0, "R1 pointer write");
        reg_acc(0, 4'h0, 2'd2, 0, 32'h8000_0007, 0, "R1 pointer full readback");
        reg_acc(1, 4'h0, 2'd1, 32'h0000_1111, 32'h0, 1, "R2 pointer 2-byte");
        reg_acc(1, 4'h1, 2'd2, 32'h0000_2222, 32'h0, 1, "R2 pointer offset 1");
        reg_acc(0, 4'h0, 2'd2, 0, 32'h8000_0007, 0, "R5 pointer unchanged");
        reg_acc(1, 4'hC, 2'd2, 32'hFFFF_FFFF, 32'h0, 0, "R7 toc write");
        reg_acc(0, 4'hC, 2'd2, 0, 32'hFFFB_E030, 0, "R7 toc masked readback");
        reg_acc(1, 4'hC, 2'd0, 32'h0, 32'h0, 1, "R2 toc byte write");
        reg_acc(0, 4'hC, 2'd2, 0, 32'hFFFB_E030, 0, "R5 toc unchanged");

        reg_acc(1, 4'h0, 2'd2, 32'h0000_1235, 32'h0, 0, "R3 pointer set");
        win_acc(1, 4'h4, 2'd2, 32'h1122_3344, 32'h0000_1234, 32'h1122_3344, 0, 0, "R6 cfg word write");
        win_acc(1, 4'h8, 2'd2, 32'h1122_3344, 32'h0000_1234, 32'h4433_2211, 0, 0, "R6 io word write");
        win_acc(1, 4'hA, 2'd1, 32'h0000_AABB, 32'h0000_1236, 32'h0000_BBAA, 0, 0, "R3 io half off2");
        win_acc(1, 4'hB, 2'd0, 32'h0000_005A, 32'h0000_1237, 32'h0000_005A, 0, 0, "R4 io byte off3");
        win_acc(0, 4'h8, 2'd1, 0, 32'h0000_1234, 32'h0, 32'hFFFF_1234, 32'h0000_3412, "R6 io half read");
        win_acc(0, 4'h6, 2'd1, 0, 32'h0000_1236, 32'h0, 32'hDEAD_1234, 32'h0000_1234, "R6 cfg half read");
        win_acc(0, 4'h8, 2'd2, 0, 32'h0000_1234, 32'h0, 32'h0A0B_0C0D, 32'h0D0C_0B0A, "R6 io word read");
        win_acc(0, 4'h5, 2'd0, 0, 32'h0000_1235, 32'h0, 32'h0000_77AB, 32'h0000_00AB, "R4 cfg byte off1");

        reg_acc(1, 4'h9, 2'd1, 32'h1, 32'h0, 1, "R4 io half off1");
        reg_acc(0, 4'hB, 2'd1, 32'h0, 32'h0, 1, "R4 io half off3");
        reg_acc(1, 4'h6, 2'd2, 32'h1, 32'h0, 1, "R4 cfg word off2");
        reg_acc(0, 4'h4, 2'd3, 32'h0, 32'h0, 1, "R4 size code 3");
        reg_acc(1, 4'h5, 2'd1, 32'h1, 32'h0, 1, "R5 cfg half off1");

        reg_acc(1, 4'h0, 2'd2, 32'hFFFF_FFFF, 32'h0, 0, "R3 pointer all ones");
        win_acc(1, 4'h9, 2'd0, 32'h0000_00C3, 32'hFFFF_FFFD, 32'h0000_00C3, 0, 0, "R3 io byte off1");
        reg_acc(0, 4'h0, 2'd2, 0, 32'hFFFF_FFFF, 0, "R1 pointer readback ones");

        repeat (3) @(negedge clk);
        check("R9 scoreboard drained", q_data.size(), 32'd0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule